// File: doc/BRIEF.md
# External Pin Interrupt Sense Controller

This block turns two external interrupt pins into two interrupt request lines. A shared two-bit sense field picks one detection mode for both pins: low level, any change, falling edge or rising edge. Each pin is brought into the clock domain through a synchronizer before any comparison is made. In the three edge modes a detected event sets a sticky pending flag for that pin. The flag stays set until the core pulses that pin's acknowledge. In low-level mode the request simply follows the synchronized pin and nothing is stored.

Software reaches the block through a small register bus. `reg_sel` low selects the control register and high selects the mask register. Writes take effect on the clock edge, and reads are combinational. A request leaves the block only when both its own enable bit and the global interrupt-enable input are high. Pins are sampled whatever their direction, so a pin that the chip drives as an output still raises requests.

Top module: `ext_pin_irq`

## Requirements
- R1: After reset both registers read 0x00, the mode is low level, and both request outputs are low.
- R2: With `reg_sel`=0, bits 6:0 of the control register are read/write and bit 7 always reads 0. Bits 1:0 are the sense field. Bits 6:2 are stored only.
- R3: With `reg_sel`=1, bits 7:4 of the mask register are read/write and bits 3:0 always read 0. Bit 7 enables pin 1 (`irq_o[1]`) and bit 6 enables pin 0 (`irq_o[0]`).
- R4: `irq_o[i]` is high only while the enable bit of pin i and `gie_i` are both 1.
- R5: With sense 00 (low level), an enabled request is high exactly while the synchronized pin is low, two clock edges after the pin changes. It drops as soon as the pin is released.
- R6: With sense 01, both rising and falling changes of a pin set its pending flag.
- R7: With sense 10, only falling changes set the pending flag, and rising changes are ignored.
- R8: With sense 11, only rising changes set the pending flag, and falling changes are ignored.
- R9: A pending flag holds until `ack_i[i]` is high at a clock edge. If a new event is detected at the same edge as the acknowledge, the flag stays set.
- R10: Pending flags are set while a pin is disabled, so enabling the pin later raises its request on the cycle after the mask write.
- R11: The two pins are detected independently under the one shared sense field. An event on one pin affects only that pin's request.
- R12: While the sense field is 00 the pending flags are cleared, so a return to an edge mode does not show events from before the switch.
- R13: In the edge modes, a pin pulse held across one clock edge produces a request. The request appears three clock edges after the pin changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register select: 0 control, 1 mask |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| pin_i | input | 2 | Raw external interrupt pins |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 2 | Per-pin acknowledge pulse that clears a pending flag |
| irq_o | output | 2 | Interrupt requests |

## Verification
The assertions check four things on every cycle. Requests are gated by the enable bit and `gie_i`. Level requests track the synchronized pin. Pending flags persist until acknowledged, and they clear when an acknowledge arrives with no new event. Edge detection in each mode and the read-as-zero bits are also checked continuously.

Other behaviour can only be shown by the bench's scenarios. These are the exact latency from a pin change to a request and the enable-after-pending behaviour. They also include the acknowledge racing a new event, the flush on a switch to level mode, and the one-cycle pulse. Each needs a specific ordering of pin, register and acknowledge activity.

// File: rtl/ext_pin_irq.sv
module ext_pin_irq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_sel,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic [1:0] pin_i,
  input  logic       gie_i,
  input  logic [1:0] ack_i,
  output logic [1:0] irq_o
);

  localparam logic [1:0] SENSE_LOW  = 2'b00;
  localparam logic [1:0] SENSE_ANY  = 2'b01;
  localparam logic [1:0] SENSE_FALL = 2'b10;
  localparam logic [1:0] SENSE_RISE = 2'b11;

  logic [6:0] ctrl_q;
  logic [3:0] mask_q;
  logic [1:0] sync_q [SYNC_STAGES];
  logic [1:0] prev_q;
  logic [1:0] pend_q;
  logic [1:0] hit_w;
  logic [1:0] req_w;

  wire [1:0] sense = ctrl_q[1:0];
  wire [1:0] smp   = sync_q[SYNC_STAGES-1];
  wire [1:0] en    = {mask_q[3], mask_q[2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
    end else if (wr_en) begin
      if (reg_sel) mask_q <= wr_data[7:4];
      else         ctrl_q <= wr_data[6:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= pin_i;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
      prev_q <= smp;
    end
  end

  always_comb begin
    case (sense)
      SENSE_ANY:  hit_w = smp ^ prev_q;
      SENSE_FALL: hit_w = prev_q & ~smp;
      SENSE_RISE: hit_w = ~prev_q & smp;
      default:    hit_w = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pend_q <= '0;
    else if (sense == SENSE_LOW) pend_q <= '0;
    else                        pend_q <= hit_w | (pend_q & ~ack_i);
  end

  assign req_w   = (sense == SENSE_LOW) ? ~smp : pend_q;
  assign irq_o   = req_w & en & {2{gie_i}};
  assign rd_data = reg_sel ? {mask_q, 4'b0000} : {1'b0, ctrl_q};

endmodule

// File: rtl/ext_pin_irq_chk.sv
module ext_pin_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] sense,
  input logic [1:0] smp,
  input logic [1:0] prev,
  input logic [1:0] pend,
  input logic [1:0] ack,
  input logic [1:0] en,
  input logic       gie,
  input logic [1:0] irq,
  input logic       reg_sel,
  input logic [7:0] rd_data
);

  p_ctrl_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> !rd_data[7]);

  p_mask_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> rd_data[3:0] == 4'h0);

  for (genvar i = 0; i < 2; i++) begin : g_pin
    p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> (gie && en[i]));

    p_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sense == 2'b00 && irq[i]) |-> !smp[i]);

    p_any_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sense == 2'b01 && smp[i] != prev[i]) |=> pend[i]);

    p_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sense == 2'b10 && prev[i] && !smp[i]) |=> pend[i]);

    p_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sense == 2'b11 && !prev[i] && smp[i]) |=> pend[i]);

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sense != 2'b00 && pend[i] && !ack[i]) |=> pend[i]);

    p_ack_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[i] && ack[i] && smp[i] == prev[i]) |=> !pend[i]);

    p_flush_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (sense == 2'b00) |=> !pend[i]);
  end

endmodule

bind ext_pin_irq ext_pin_irq_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sense   (ctrl_q[1:0]),
  .smp     (smp),
  .prev    (prev_q),
  .pend    (pend_q),
  .ack     (ack_i),
  .en      ({mask_q[3], mask_q[2]}),
  .gie     (gie_i),
  .irq     (irq_o),
  .reg_sel (reg_sel),
  .rd_data (rd_data)
);

// File: tb/ext_pin_irq_bench.sv
module ext_pin_irq_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_sel = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [1:0] pin_i = '0;
  logic       gie_i = 1'b0;
  logic [1:0] ack_i = '0;
  logic [1:0] irq_o;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  ext_pin_irq u_ext_pin_irq (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .pin_i(pin_i), .gie_i(gie_i),
    .ack_i(ack_i), .irq_o(irq_o)
  );

  // {mode[1:0], pin before, pin after, expected request}
  localparam logic [4:0] VEC [8] = '{
    {2'b00, 1'b1, 1'b0, 1'b1},
    {2'b00, 1'b0, 1'b1, 1'b0},
    {2'b01, 1'b0, 1'b1, 1'b1},
    {2'b01, 1'b1, 1'b0, 1'b1},
    {2'b10, 1'b1, 1'b0, 1'b1},
    {2'b10, 1'b0, 1'b1, 1'b0},
    {2'b11, 1'b0, 1'b1, 1'b1},
    {2'b11, 1'b1, 1'b0, 1'b0}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    reg_sel = sel; wr_data = d; wr_en = 1'b1;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    reg_sel = sel;
    #1 d = rd_data;
  endtask

  task automatic ack_all();
    ack_i = 2'b11; tick(1); ack_i = 2'b00;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    rd(1'b0, d); chk("R1 ctrl reset", d, 8'h00);
    rd(1'b1, d); chk("R1 mask reset", d, 8'h00);
    chk("R1 irq reset", {6'b0, irq_o}, 8'h00);

    wr(1'b0, 8'hFF); rd(1'b0, d); chk("R2 ctrl bit7 zero", d, 8'h7F);
    wr(1'b0, 8'h54); rd(1'b0, d); chk("R2 ctrl rw", d, 8'h54);
    wr(1'b1, 8'hFF); rd(1'b1, d); chk("R3 mask low zero", d, 8'hF0);
    wr(1'b1, 8'h30); rd(1'b1, d); chk("R3 mask rw", d, 8'h30);

    gie_i = 1'b1;
    foreach (VEC[k]) begin
      wr(1'b0, {6'b0, VEC[k][4:3]});
      wr(1'b1, 8'hC0);
      pin_i = {2{VEC[k][2]}};
      tick(4);
      ack_all();
      pin_i = {2{VEC[k][1]}};
      tick(3);
      chk($sformatf("R5-R8 vector %0d", k), {6'b0, irq_o}, {6'b0, {2{VEC[k][0]}}});
    end

    wr(1'b0, 8'h00); wr(1'b1, 8'hC0);
    pin_i = 2'b00; tick(3);
    gie_i = 1'b0; #1 chk("R4 gie off", {6'b0, irq_o}, 8'h00);
    gie_i = 1'b1; #1 chk("R4 gie on", {6'b0, irq_o}, 8'h03);
    wr(1'b1, 8'h80); chk("R3 R4 bit7 enables pin1", {6'b0, irq_o}, 8'h02);
    wr(1'b1, 8'h40); chk("R3 R4 bit6 enables pin0", {6'b0, irq_o}, 8'h01);
    wr(1'b1, 8'hC0); pin_i = 2'b11; tick(2);
    chk("R5 level release", {6'b0, irq_o}, 8'h00);

    wr(1'b0, 8'h03); wr(1'b1, 8'h00);
    pin_i = 2'b00; tick(4); ack_all();
    pin_i = 2'b11; tick(3);
    chk("R10 disabled no irq", {6'b0, irq_o}, 8'h00);
    wr(1'b1, 8'hC0);
    chk("R10 pending shows on enable", {6'b0, irq_o}, 8'h03);

    tick(5); chk("R9 sticky", {6'b0, irq_o}, 8'h03);
    ack_i = 2'b01; tick(1); ack_i = 2'b00;
    chk("R9 ack clears pin0 only", {6'b0, irq_o}, 8'h02);
    ack_all(); chk("R9 ack clears", {6'b0, irq_o}, 8'h00);

    wr(1'b0, 8'h01);
    pin_i = 2'b00; tick(3);
    chk("R6 any change set", {6'b0, irq_o}, 8'h03);
    pin_i = 2'b11; tick(2);
    ack_i = 2'b11; tick(1); ack_i = 2'b00;
    chk("R9 event beats ack", {6'b0, irq_o}, 8'h03);
    ack_all(); chk("R9 clear after race", {6'b0, irq_o}, 8'h00);

    wr(1'b0, 8'h02);
    pin_i = 2'b01; tick(3);
    chk("R11 pin1 only", {6'b0, irq_o}, 8'h02);
    ack_all();

    pin_i = 2'b11; tick(4); ack_all();
    pin_i = 2'b00; tick(3);
    chk("R12 pending before flush", {6'b0, irq_o}, 8'h03);
    pin_i = 2'b11; tick(3);
    wr(1'b0, 8'h00); tick(1);
    chk("R12 level mode pins high", {6'b0, irq_o}, 8'h00);
    wr(1'b0, 8'h02); tick(1);
    chk("R12 no stale pending", {6'b0, irq_o}, 8'h00);

    wr(1'b0, 8'h03);
    pin_i = 2'b00; tick(4); ack_all();
    pin_i = 2'b11; tick(1); pin_i = 2'b00;
    tick(2);
    chk("R13 short pulse", {6'b0, irq_o}, 8'h03);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule